// File: doc/BRIEF.md
# MII Carrier-Sense and Isolate Gating

This block sits between the internal datapath of an Ethernet PHY and its MII pins. It derives the carrier-sense output from two internal flags, one for receive activity and one for transmit activity. A configuration bit selects between a repeater role and a node role. In the repeater role only receive activity raises carrier sense. In the node role either kind of activity raises it. The repeater role at 100 Mb/s also raises an enable for the carrier-integrity monitor, which detects and reports bad start-of-stream delimiters.

The block also implements the isolate function. While isolate is set, the MII transmit inputs are forced inactive before they reach the datapath. In the same state, every MII output driver receives a deasserted enable, so that the pin floats. A request to keep generating idles or link pulses on the line stays active in either state.

Both configuration bits have hardware reset defaults. The role bit takes its default from a strap pin that is sampled during reset. The isolate bit defaults to 1 only when the PHY address is zero. After reset, software can rewrite either bit through simple write strobes.

Top module: `mii_csgate_top`

## Requirements
- R1: When `rptr_mode` is 1, `crs` equals `rx_active`, and `tx_active` has no effect on it (combinational, same cycle).
- R2: When `rptr_mode` is 0, `crs` is `rx_active OR tx_active` (combinational, same cycle).
- R3: On every clock edge with `rst_n` low, `rptr_mode` loads `strap_rptr`. A strap held high (the default of a floating pin) gives the repeater role, and a strap driven low gives the node role.
- R4: `cim_en` is 1 exactly when `rptr_mode` is 1 and `speed_100` is 1.
- R5: On every clock edge with `rst_n` low, `iso_mode` loads 1 if `phy_addr` is all zeros, and 0 otherwise.
- R6: The gated outputs `dp_txd`, `dp_tx_en` and `dp_tx_er` are registered. One clock after a cycle with `iso_mode` = 1 they are all 0. One clock after a cycle with `iso_mode` = 0 they equal the MII inputs of that cycle. All three are 0 after reset.
- R7: `oe` is registered and is all zeros after reset. One clock after a cycle with `iso_mode` = 1 it is all zeros, and one clock after a cycle with `iso_mode` = 0 it is all ones. The bit order is: 0 TX_CLK, 1 RX_CLK, 2 RX_DV, 3 RX_ER, 4 COL, 5 CRS, 6 and up RXD[0..DATA_W-1].
- R8: `idle_req` is 0 during reset and 1 on every cycle after reset, whatever the value of `iso_mode`.
- R9: A write strobe (`wr_rptr_en` or `wr_iso_en`) that is high at a clock edge loads its value bit into `rptr_mode` or `iso_mode` at that edge, so the new value shows on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_rptr | input | 1 | Role strap, sampled during reset (1 = repeater) |
| phy_addr | input | ADDR_W | PHY address, decides the isolate default |
| speed_100 | input | 1 | 1 when the link runs at 100 Mb/s |
| rx_active | input | 1 | Internal receive-activity flag |
| tx_active | input | 1 | Internal transmit-activity flag |
| wr_rptr_en | input | 1 | Write strobe for the role bit |
| wr_rptr_val | input | 1 | Value written to the role bit |
| wr_iso_en | input | 1 | Write strobe for the isolate bit |
| wr_iso_val | input | 1 | Value written to the isolate bit |
| mii_txd | input | DATA_W | MII transmit data |
| mii_tx_en | input | 1 | MII transmit enable |
| mii_tx_er | input | 1 | MII transmit error |
| dp_txd | output | DATA_W | Gated transmit data to the datapath |
| dp_tx_en | output | 1 | Gated transmit enable to the datapath |
| dp_tx_er | output | 1 | Gated transmit error to the datapath |
| crs | output | 1 | Carrier sense |
| cim_en | output | 1 | Carrier-integrity monitor enable |
| rptr_mode | output | 1 | Current role bit |
| iso_mode | output | 1 | Current isolate bit |
| oe | output | DATA_W+6 | Output-driver enables for the MII outputs |
| idle_req | output | 1 | Request to keep line idles or link pulses going |

## Verification
The bench builds the block with its default parameters: a 5-bit address and a 4-bit data path, which gives a 10-bit enable vector. With these sizes every reset default can be covered exhaustively, over all 32 addresses and both strap levels. The carrier and monitor logic is swept over all 16 combinations of role, receive flag, transmit flag and speed. The isolate gate is swept over every transmit data nibble, with both enable and error levels, in both isolate states. Each expected value is computed directly from the stimulus.

// File: rtl/mii_csgate_pkg.sv
// Package: shared constants for the MII carrier-sense / isolate gating block.
// Assumes the enable vector keeps fixed-function pins first and data pins after.
package mii_csgate_pkg;
    localparam int OE_TX_CLK = 0;
    localparam int OE_RX_CLK = 1;
    localparam int OE_RX_DV  = 2;
    localparam int OE_RX_ER  = 3;
    localparam int OE_COL    = 4;
    localparam int OE_CRS    = 5;
    localparam int OE_FIXED  = 6;   // index of RXD[0]

    typedef struct packed {
        logic rptr;
        logic iso;
    } csgate_cfg_t;
endpackage

// File: rtl/mii_csgate_cfg.sv
// Module: configuration bits (role and isolate).
// Loads hardware defaults on every reset edge and accepts software writes
// afterwards; a write is visible on the cycle after its edge.
module mii_csgate_cfg
    import mii_csgate_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_rptr,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic              wr_rptr_en,
    input  logic              wr_rptr_val,
    input  logic              wr_iso_en,
    input  logic              wr_iso_val,
    output csgate_cfg_t       cfg
);
    localparam logic [ADDR_W-1:0] ADDR_ZERO = '0;

    // Hold role and isolate bits: strap/address defaults, then writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.rptr <= strap_rptr;
            cfg.iso  <= (phy_addr == ADDR_ZERO);
        end else begin
            if (wr_rptr_en) cfg.rptr <= wr_rptr_val;
            if (wr_iso_en)  cfg.iso  <= wr_iso_val;
        end
    end
endmodule

// File: rtl/mii_csgate_crs.sv
// Module: carrier-sense and integrity-monitor enable generation.
// Purely combinational; assumes the activity flags are already synchronous.
module mii_csgate_crs (
    input  logic rptr,
    input  logic speed_100,
    input  logic rx_active,
    input  logic tx_active,
    output logic crs,
    output logic cim_en
);
    // Repeater counts receive only; node counts receive or transmit.
    always_comb begin
        crs    = rx_active | (tx_active & ~rptr);
        cim_en = rptr & speed_100;
    end
endmodule

// File: rtl/mii_csgate_iso.sv
// Module: isolate gate. Registers the transmit inputs toward the datapath,
// forcing them inactive while isolated, and registers one enable per MII
// output so that the drivers change cleanly when isolate toggles.
module mii_csgate_iso #(
    parameter int DATA_W = 4,
    parameter int OE_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iso,
    input  logic [DATA_W-1:0] mii_txd,
    input  logic              mii_tx_en,
    input  logic              mii_tx_er,
    output logic [DATA_W-1:0] dp_txd,
    output logic              dp_tx_en,
    output logic              dp_tx_er,
    output logic [OE_W-1:0]   oe,
    output logic              idle_req
);
    // Transmit path: pass registered inputs, or zeros while isolated.
    always_ff @(posedge clk) begin
        if (!rst_n || iso) begin
            dp_txd   <= '0;
            dp_tx_en <= 1'b0;
            dp_tx_er <= 1'b0;
        end else begin
            dp_txd   <= mii_txd;
            dp_tx_en <= mii_tx_en;
            dp_tx_er <= mii_tx_er;
        end
    end

    // One enable flop per output pin, all following the isolate bit.
    for (genvar i = 0; i < OE_W; i++) begin : g_oe
        always_ff @(posedge clk) begin
            if (!rst_n) oe[i] <= 1'b0;
            else        oe[i] <= ~iso;
        end
    end

    // Line idle request stays up after reset regardless of isolate.
    always_ff @(posedge clk) begin
        if (!rst_n) idle_req <= 1'b0;
        else        idle_req <= 1'b1;
    end
endmodule

// File: rtl/mii_csgate_top.sv
// Module: top of the MII carrier-sense and isolate gating block.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module mii_csgate_top
    import mii_csgate_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 4,
    localparam int OE_W  = OE_FIXED + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_rptr,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic              speed_100,
    input  logic              rx_active,
    input  logic              tx_active,
    input  logic              wr_rptr_en,
    input  logic              wr_rptr_val,
    input  logic              wr_iso_en,
    input  logic              wr_iso_val,
    input  logic [DATA_W-1:0] mii_txd,
    input  logic              mii_tx_en,
    input  logic              mii_tx_er,
    output logic [DATA_W-1:0] dp_txd,
    output logic              dp_tx_en,
    output logic              dp_tx_er,
    output logic              crs,
    output logic              cim_en,
    output logic              rptr_mode,
    output logic              iso_mode,
    output logic [OE_W-1:0]   oe,
    output logic              idle_req
);
    csgate_cfg_t cfg;

    mii_csgate_cfg #(.ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .strap_rptr(strap_rptr), .phy_addr(phy_addr),
        .wr_rptr_en(wr_rptr_en), .wr_rptr_val(wr_rptr_val),
        .wr_iso_en(wr_iso_en), .wr_iso_val(wr_iso_val), .cfg(cfg)
    );

    mii_csgate_crs u_crs (
        .rptr(cfg.rptr), .speed_100(speed_100), .rx_active(rx_active),
        .tx_active(tx_active), .crs(crs), .cim_en(cim_en)
    );

    mii_csgate_iso #(.DATA_W(DATA_W), .OE_W(OE_W)) u_iso (
        .clk(clk), .rst_n(rst_n), .iso(cfg.iso), .mii_txd(mii_txd),
        .mii_tx_en(mii_tx_en), .mii_tx_er(mii_tx_er), .dp_txd(dp_txd),
        .dp_tx_en(dp_tx_en), .dp_tx_er(dp_tx_er), .oe(oe), .idle_req(idle_req)
    );

    // Expose configuration bits.
    always_comb begin
        rptr_mode = cfg.rptr;
        iso_mode  = cfg.iso;
    end
endmodule

// File: rtl/mii_csgate_chk.sv
// Module: assertion checker for mii_csgate_top, attached by bind below.
// "armed" marks cycles whose previous cycle was already out of reset.
module mii_csgate_chk #(
    parameter int DATA_W = 4,
    parameter int OE_W   = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              speed_100,
    input logic              rx_active,
    input logic              tx_active,
    input logic              wr_iso_en,
    input logic              wr_iso_val,
    input logic              wr_rptr_en,
    input logic              wr_rptr_val,
    input logic [DATA_W-1:0] dp_txd,
    input logic              dp_tx_en,
    input logic              dp_tx_er,
    input logic              crs,
    input logic              cim_en,
    input logic              rptr_mode,
    input logic              iso_mode,
    input logic [OE_W-1:0]   oe,
    input logic              idle_req
);
    logic armed;

    // Track whether the previous edge was outside reset.
    always_ff @(posedge clk) armed <= rst_n;

    // R1
    rptr_tx_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rptr_mode && !rx_active) |-> !crs);
    // R2
    node_tx_crs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rptr_mode && tx_active) |-> crs);
    // R4
    cim_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cim_en |-> (rptr_mode && speed_100));
    // R6
    iso_tx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(iso_mode)) |-> (dp_txd == '0 && !dp_tx_en && !dp_tx_er));
    // R7
    iso_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(iso_mode)) |-> (oe == '0));
    // R7
    iso_oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(iso_mode)) |-> (&oe));
    // R8
    idle_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> idle_req);
    // R9
    iso_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(wr_iso_en)) |-> (iso_mode == $past(wr_iso_val)));
    // R9
    rptr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(wr_rptr_en)) |-> (rptr_mode == $past(wr_rptr_val)));
endmodule

bind mii_csgate_top mii_csgate_chk #(.DATA_W(DATA_W), .OE_W(OE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .rx_active(rx_active),
    .tx_active(tx_active), .wr_iso_en(wr_iso_en), .wr_iso_val(wr_iso_val),
    .wr_rptr_en(wr_rptr_en), .wr_rptr_val(wr_rptr_val), .dp_txd(dp_txd),
    .dp_tx_en(dp_tx_en), .dp_tx_er(dp_tx_er), .crs(crs), .cim_en(cim_en),
    .rptr_mode(rptr_mode), .iso_mode(iso_mode), .oe(oe), .idle_req(idle_req)
);

// File: tb/mii_csgate_top_bench.sv
// Bench: exhaustive sweeps of reset defaults, carrier logic and isolate gate.
module mii_csgate_top_bench;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 4;
    localparam int OE_W   = 6 + DATA_W;

    logic clk = 1'b0;
    logic rst_n, strap_rptr, speed_100, rx_active, tx_active;
    logic wr_rptr_en, wr_rptr_val, wr_iso_en, wr_iso_val, mii_tx_en, mii_tx_er;
    logic [ADDR_W-1:0] phy_addr;
    logic [DATA_W-1:0] mii_txd, dp_txd;
    logic dp_tx_en, dp_tx_er, crs, cim_en, rptr_mode, iso_mode, idle_req;
    logic [OE_W-1:0] oe;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    mii_csgate_top u_mii_csgate_top (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply one rising edge; return just after the following falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        {strap_rptr, speed_100, rx_active, tx_active} = '0;
        {wr_rptr_en, wr_rptr_val, wr_iso_en, wr_iso_val} = '0;
        {mii_tx_en, mii_tx_er} = '0;
        mii_txd = '0;
        phy_addr = '0;
        rst_n = 1'b0;
        @(negedge clk);

        // R3 R5 R7 R8: reset defaults for every address and strap level.
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 32; a++) begin
                rst_n = 1'b0;
                strap_rptr = s[0];
                phy_addr = a[ADDR_W-1:0];
                mii_tx_en = 1'b1;
                tick();
                chk("R3 rptr default", rptr_mode, s[0]);
                chk("R5 iso default", iso_mode, (a == 0));
                chk("R7 oe in reset", oe, '0);
                chk("R6 dp in reset", {dp_txd, dp_tx_en, dp_tx_er}, '0);
                chk("R8 idle in reset", idle_req, 1'b0);
                rst_n = 1'b1;
                strap_rptr = ~s[0];
                phy_addr = ~a[ADDR_W-1:0];
                tick();
                chk("R3 strap ignored after reset", rptr_mode, s[0]);
                chk("R5 addr ignored after reset", iso_mode, (a == 0));
                chk("R7 oe after reset", oe, (a == 0) ? '0 : {OE_W{1'b1}});
                chk("R8 idle after reset", idle_req, 1'b1);
            end
        end
        mii_tx_en = 1'b0;

        // R1 R2 R4 R9: role written, carrier/monitor swept.
        for (int m = 0; m < 16; m++) begin
            wr_rptr_en = 1'b1;
            wr_rptr_val = m[3];
            tick();
            wr_rptr_en = 1'b0;
            chk("R9 rptr write", rptr_mode, m[3]);
            rx_active = m[0];
            tx_active = m[1];
            speed_100 = m[2];
            #1;
            if (m[3]) chk("R1 crs repeater", crs, m[0]);
            else      chk("R2 crs node", crs, m[0] | m[1]);
            chk("R4 cim_en", cim_en, m[3] & m[2]);
        end
        {rx_active, tx_active, speed_100} = '0;

        // R6 R7 R8 R9: isolate written, transmit gate swept.
        for (int i = 0; i < 2; i++) begin
            wr_iso_en = 1'b1;
            wr_iso_val = i[0];
            tick();
            wr_iso_en = 1'b0;
            chk("R9 iso write", iso_mode, i[0]);
            for (int v = 0; v < 64; v++) begin
                mii_txd = v[3:0];
                mii_tx_en = v[4];
                mii_tx_er = v[5];
                tick();
                chk("R6 tx gate", {dp_txd, dp_tx_en, dp_tx_er},
                    i[0] ? 32'd0 : {26'd0, v[3:0], v[4], v[5]});
                chk("R7 oe", oe, i[0] ? '0 : {OE_W{1'b1}});
                chk("R8 idle under isolate", idle_req, 1'b1);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule